// File: doc/BRIEF.md
# Sensor Code to Temperature Interpolator

This block turns a raw reading from an on-die temperature sensor into a signed temperature in millidegrees Celsius. The sensor's response is held in a fixed calibration table of 36 code/temperature pairs. Codes fall as temperature rises, and the table points sit 5000 millidegrees apart. The first point is a guard entry at code 4095 (-40000). The last point is a guard entry at code 0 (125000). Between them, code 3800 stands for -40000, code 3728 for 0 and code 3421 for 125000.

A conversion is offered on a valid/ready input. Once a code is taken, the block runs a binary search over the table, one probe per cycle. The search finds the smallest index m with table code[m] <= input. The block then computes temp[m-1] + ((temp[m]-temp[m-1]) * (code[m-1]-input)) / (code[m-1]-code[m]). The division is done by a restoring divider that yields one quotient bit per cycle and truncates. The result comes back as a one-cycle done pulse carrying the temperature and an error flag.

Beside the converter there is a combinational reverse lookup for threshold setup. Given a temperature, it returns the table code when the temperature equals one of the interior table points, and 0 otherwise.

Top module: `code_temp_interp`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A code is taken on a rising edge where `req_valid` and `req_ready` are both high. After an in-range code is taken, `req_ready` is low until the cycle in which its result is presented.
- R2: A request offered while `req_ready` is low is not taken. It does not alter the result in flight and produces no later result.
- R3: A taken code above 4095 (any bit above bit 11 set) produces, on the next cycle, `res_valid`=1 with `res_err`=1 and `res_temp`=0.
- R4: For a taken code c of 4095 or below, `res_err`=0 and `res_temp` = T(m-1) + (T(m)-T(m-1))*(C(m-1)-c) / (C(m-1)-C(m)), truncated. Here m is the smallest index 1..35 with C(m) <= c. T(0)=-40000, T(35)=125000 and T(i)=-40000+5000*(i-1) otherwise. The codes C(0..35) are 4095, 3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737, 3728, 3718, 3708, 3698, 3688, 3678, 3667, 3656, 3645, 3634, 3623, 3611, 3600, 3588, 3575, 3563, 3550, 3537, 3524, 3510, 3496, 3482, 3467, 3452, 3437, 3421, 0.
- R5: Codes that sit exactly on a table point give that point's temperature: 3800 gives -40000, 3728 gives 0 and 3421 gives 125000.
- R6: Every code from 3800 to 4095 gives -40000, and every code from 0 to 3421 gives 125000.
- R7: Each taken code yields exactly one result, with `res_valid` high for a single cycle. The result side has no back-pressure.
- R8: `thr_code` equals the table code C(k) when `thr_temp` equals -40000+5000*(k-1) for some k in 1..34. So -40000 gives 3800 and 125000 gives 3421.
- R9: `thr_code` is 0 for any temperature that is not one of those 34 values, including values below -40000 or above 125000.
- R10: After reset `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A code is offered |
| req_ready | output | 1 | Block is idle and will take the offered code |
| req_code | input | IN_W (16) | Raw sensor code; values above 4095 are invalid |
| res_valid | output | 1 | One-cycle pulse: result is present |
| res_temp | output | TEMP_W (32) | Signed temperature in millidegrees |
| res_err | output | 1 | Result is an invalid-code error |
| thr_temp | input | TEMP_W (32) | Signed temperature for the reverse lookup |
| thr_code | output | 12 | Table code for `thr_temp`, or 0 |

## Verification
The assertions rely on a few things about the inputs. `thr_temp` is a settled value, so a nonzero `thr_code` can be checked against the temperature grid in the same cycle. The requester may withdraw an offer that was not taken, since the result-side checks only consider transfers in which `req_ready` was high. The stimulus offers each code at a falling edge and holds it until it is taken. It then waits for the single done pulse, which keeps the result side free of back-pressure. Deliberate offers made while the block is busy are pulsed for one cycle and then withdrawn.

// File: rtl/cti_pkg.sv
package cti_pkg;
  parameter int CODE_W  = 12;
  parameter int TEMP_W  = 32;
  parameter int CAL_N   = 36;
  parameter int IDX_W   = $clog2(CAL_N);
  parameter int T_MIN   = -40000;
  parameter int T_MAX   = 125000;
  parameter int T_STEP  = 5000;
  parameter int CODE_MAX = (1 << CODE_W) - 1;

  // Calibration codes, strictly falling; guard entries at both ends.
  localparam logic [CODE_W-1:0] CAL_CODES [CAL_N] = '{
    12'd4095, 12'd3800, 12'd3792, 12'd3783, 12'd3774, 12'd3765,
    12'd3756, 12'd3747, 12'd3737, 12'd3728, 12'd3718, 12'd3708,
    12'd3698, 12'd3688, 12'd3678, 12'd3667, 12'd3656, 12'd3645,
    12'd3634, 12'd3623, 12'd3611, 12'd3600, 12'd3588, 12'd3575,
    12'd3563, 12'd3550, 12'd3537, 12'd3524, 12'd3510, 12'd3496,
    12'd3482, 12'd3467, 12'd3452, 12'd3437, 12'd3421, 12'd0
  };

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DIVIDE} cti_state_e;

  function automatic logic [CODE_W-1:0] cal_code(input logic [IDX_W-1:0] idx);
    return CAL_CODES[idx];
  endfunction

  // Temperature of a table point, computed from the 5000 grid.
  function automatic logic signed [TEMP_W-1:0] cal_temp(input logic [IDX_W-1:0] idx);
    if (idx == '0)
      return TEMP_W'(T_MIN);
    else if (int'(idx) >= CAL_N - 1)
      return TEMP_W'(T_MAX);
    else
      return TEMP_W'(T_MIN + T_STEP * (int'(idx) - 1));
  endfunction
endpackage

// File: rtl/cti_divider.sv
module cti_divider #(
  parameter int NW = 18,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [DW-1:0]    rem;
  logic [NW-1:0]    quo;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DW:0]      trial;
  logic             fits;

  assign trial = {rem, quo[NW-1]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      quo  <= dividend;
      cnt  <= CNT_W'(NW);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (fits) begin
        rem <= trial[DW-1:0] - divisor;
        quo <= {quo[NW-2:0], 1'b1};
      end else begin
        rem <= trial[DW-1:0];
        quo <= {quo[NW-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/cti_thresh_lookup.sv
module cti_thresh_lookup
  import cti_pkg::*;
(
  input  logic signed [TEMP_W-1:0] thr_temp,
  output logic [CODE_W-1:0]        thr_code
);
  // Interior table points only; guard entries never match.
  logic [CAL_N-2:1] hit;

  for (genvar k = 1; k <= CAL_N - 2; k++) begin : g_hit
    assign hit[k] = (thr_temp == cal_temp(IDX_W'(k)));
  end

  always_comb begin
    thr_code = '0;
    for (int i = 1; i <= CAL_N - 2; i++)
      if (hit[i]) thr_code = cal_code(IDX_W'(i));
  end
endmodule

// File: rtl/code_temp_interp.sv
module code_temp_interp
  import cti_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int NUM_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [IN_W-1:0]          req_code,
  output logic                     res_valid,
  output logic signed [TEMP_W-1:0] res_temp,
  output logic                     res_err,
  input  logic signed [TEMP_W-1:0] thr_temp,
  output logic [CODE_W-1:0]        thr_code
);
  cti_state_e              st;
  logic [CODE_W-1:0]       code_q;
  logic [IDX_W-1:0]        lo, hi, mid, lo_prev;
  logic signed [TEMP_W-1:0] base_q;
  logic                    oversize;
  logic                    div_start, div_done;
  logic [CODE_W-1:0]       seg_top, seg_bot, gap, denom;
  logic [NUM_W-1:0]        step_u, dividend, quo;

  assign oversize = |req_code[IN_W-1:CODE_W];
  assign mid      = IDX_W'(({1'b0, lo} + {1'b0, hi}) >> 1);
  assign lo_prev  = lo - 1'b1;

  // Bracketing segment once the search has closed on lo.
  assign seg_top  = cal_code(lo_prev);
  assign seg_bot  = cal_code(lo);
  assign gap      = seg_top - code_q;
  assign denom    = seg_top - seg_bot;
  assign step_u   = NUM_W'(cal_temp(lo) - cal_temp(lo_prev));
  assign dividend = step_u * NUM_W'(gap);
  assign div_start = (st == ST_SEARCH) && (lo == hi);

  cti_divider #(.NW(NUM_W), .DW(CODE_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (dividend),
    .divisor  (denom),
    .done     (div_done),
    .quotient (quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      code_q    <= '0;
      lo        <= '0;
      hi        <= '0;
      base_q    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_temp  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          if (oversize) begin
            res_valid <= 1'b1;
            res_err   <= 1'b1;
            res_temp  <= '0;
          end else begin
            code_q <= req_code[CODE_W-1:0];
            lo     <= IDX_W'(1);
            hi     <= IDX_W'(CAL_N - 1);
            st     <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (lo == hi) begin
            base_q <= cal_temp(lo_prev);
            st     <= ST_DIVIDE;
          end else if (cal_code(mid) <= code_q) begin
            hi <= mid;
          end else begin
            lo <= mid + 1'b1;
          end
        end
        ST_DIVIDE: if (div_done) begin
          res_valid <= 1'b1;
          res_err   <= 1'b0;
          res_temp  <= base_q + $signed(TEMP_W'(quo));
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);

  cti_thresh_lookup i_thr (
    .thr_temp (thr_temp),
    .thr_code (thr_code)
  );
endmodule

// File: rtl/cti_checker.sv
module cti_checker
  import cti_pkg::*;
#(
  parameter int IN_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [IN_W-1:0]          req_code,
  input logic                     res_valid,
  input logic signed [TEMP_W-1:0] res_temp,
  input logic                     res_err,
  input logic signed [TEMP_W-1:0] thr_temp,
  input logic [CODE_W-1:0]        thr_code
);
  logic bad_code;
  assign bad_code = (req_code >> CODE_W) != '0;

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad_code) |=> !req_ready);

  // R1
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> req_ready);

  // R3
  err_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_code) |=> (res_valid && res_err));

  // R3
  err_zero_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_temp == 0));

  // R4
  temp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (res_temp >= T_MIN && res_temp <= T_MAX));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |=> !res_valid);

  // R9
  thr_on_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_code != '0) |-> (thr_temp >= T_MIN && thr_temp <= T_MAX &&
                          ((thr_temp - T_MIN) % T_STEP) == 0));
endmodule

bind code_temp_interp cti_checker #(.IN_W(IN_W)) i_cti_checker (.*);

// File: tb/test_code_temp_interp.sv
`timescale 1ns/1ps
module test_code_temp_interp;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [15:0]        req_code = '0;
  logic               res_valid;
  logic signed [31:0] res_temp;
  logic               res_err;
  logic signed [31:0] thr_temp = '0;
  logic [11:0]        thr_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  code_temp_interp i_code_temp_interp (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
    .res_valid(res_valid), .res_temp(res_temp), .res_err(res_err),
    .thr_temp(thr_temp), .thr_code(thr_code)
  );

  function automatic int bt_code(input int i);
    int t [36] = '{4095, 3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737,
                   3728, 3718, 3708, 3698, 3688, 3678, 3667, 3656, 3645,
                   3634, 3623, 3611, 3600, 3588, 3575, 3563, 3550, 3537,
                   3524, 3510, 3496, 3482, 3467, 3452, 3437, 3421, 0};
    return t[i];
  endfunction

  function automatic int bt_temp(input int i);
    if (i == 0) return -40000;
    if (i == 35) return 125000;
    return -40000 + 5000 * (i - 1);
  endfunction

  function automatic int ref_temp(input int code);
    int m = 35;
    for (int i = 1; i <= 35; i++)
      if (bt_code(i) <= code) begin m = i; break; end
    return bt_temp(m - 1) + ((bt_temp(m) - bt_temp(m - 1)) * (bt_code(m - 1) - code))
                            / (bt_code(m - 1) - bt_code(m));
  endfunction

  function automatic int ref_thr(input int t);
    if (t < -40000 || t > 125000) return 0;
    if (((t + 40000) % 5000) != 0) return 0;
    return bt_code((t + 40000) / 5000 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offer one code, wait for its result; lat = cycles after the taking edge.
  task automatic run_one(input logic [15:0] c, output int t, output bit e, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_code  = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 200) begin @(negedge clk); lat++; end
    t = res_temp;
    e = res_err;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", res_valid, 0);
  endtask

  task automatic conv_check(input logic [15:0] c);
    int t; bit e; int lat; string tag;
    run_one(c, t, e, lat);
    if (c > 16'd4095) begin
      chk(e == 1'b1 && lat == 0, "R3", {e, lat[7:0]}, 256);
      chk(t == 0, "R3", t, 0);
    end else begin
      if (c == 16'd3800 || c == 16'd3728 || c == 16'd3421) tag = "R5";
      else if (c >= 16'd3800 || c <= 16'd3421) tag = "R6";
      else tag = "R4";
      chk(e == 1'b0 && t == ref_temp(int'(c)), tag, t, ref_temp(int'(c)));
    end
  endtask

  task automatic thr_check(input int t);
    thr_temp = t;
    #1;
    chk(thr_code == 12'(ref_thr(t)), (ref_thr(t) != 0) ? "R8" : "R9",
        thr_code, ref_thr(t));
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int t; bit e; int lat; int hits;
    void'($urandom(32'h1c0d_e5ed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(req_ready == 1'b1, "R10", req_ready, 1);
    chk(res_valid == 1'b0, "R10", res_valid, 0);

    // R5 directed table points
    conv_check(16'd3800);
    conv_check(16'd3728);
    conv_check(16'd3421);
    // R3 invalid codes
    conv_check(16'd4096);
    conv_check(16'hFFFF);
    conv_check(16'd4096);

    // R2: offer while busy, then withdraw
    @(negedge clk);
    req_valid = 1'b1; req_code = 16'd3600;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", req_ready, 0);
    req_valid = 1'b1; req_code = 16'd3421;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 200) begin @(negedge clk); lat++; end
    chk(res_valid && !res_err && res_temp == ref_temp(3600), "R2", res_temp, ref_temp(3600));
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    hits = 0;
    repeat (40) begin @(negedge clk); if (res_valid) hits++; end
    chk(hits == 0, "R2", hits, 0);

    // Full sweep against the reference model (R4, R6)
    for (int c = 0; c <= 4095; c++) conv_check(16'(c));

    // Random mix of valid and invalid codes
    for (int i = 0; i < 200; i++) begin
      logic [15:0] c;
      c = ($urandom % 4 == 0) ? 16'($urandom) : 16'(3380 + $urandom % 460);
      conv_check(c);
    end

    // Reverse lookup: every grid point (R8), off-grid and out of range (R9)
    for (int k = 0; k <= 33; k++) thr_check(-40000 + 5000 * k);
    thr_check(125000);
    thr_check(-45000);
    thr_check(130000);
    thr_check(-39999);
    thr_check(1);
    thr_check(-40000 - 5000);
    for (int i = 0; i < 100; i++) thr_check(int'($urandom % 190000) - 50000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule